// File: doc/BRIEF.md
# Timer Set/Clear Control Bank

This block keeps the shared control words of a bank of up to sixteen timer channels and one watchdog slot. Software reaches it over a simple 32-bit register bus with a one-cycle write strobe and a combinational read port. Four words live here: which channel counters are enabled, which channel clocks (and the watchdog clock) are stopped, which match events are pending, and which of those events are masked. Every word can be written whole at its base address, or changed bit by bit through a write-one-to-set alias and a write-one-to-clear alias, so that software controlling one channel never needs a read-modify-write that could disturb another.

Each channel delivers a full-match pulse and a half-match pulse. The block latches full-match events in the low half of the pending word and half-match events in the high half, and drives one registered, level-sensitive interrupt that is high while any unmasked pending bit exists. One configured channel (channel 5 by default) is served by a dedicated interrupt line elsewhere, so both of its bits are kept out of the shared interrupt. A read-only status word reports, per channel, that a counter reset is still in progress, together with a second per-channel indication supplied by the channel logic.

Top module: `timer_ctrl_bank`

## Requirements
- R1: After reset the enable, stop, pending and mask words all read zero, every interrupt is unmasked, and `irq`, `cntEnable`, `chStop` and `wdtStop` are low.
- R2: The enable word is written whole at 0x10, set by ones written to 0x14 and cleared by ones written to 0x18; bit n drives `cntEnable[n]`, bits with no channel read zero, and zero bits written to an alias leave the word unchanged.
- R3: The stop word is written whole at 0x1C, set by ones at 0x2C and cleared by ones at 0x3C; bit n drives `chStop[n]` and bit 16 drives `wdtStop`, all other bits read zero.
- R4: The mask word is written whole at 0x30, set by ones at 0x34 and cleared by ones at 0x38; a set bit keeps the matching pending bit out of the interrupt.
- R5: A high `fullEvt[n]` on a clock edge sets pending bit n and a high `halfEvt[n]` sets pending bit n+16; the pending word is also written whole at 0x20, set at 0x24 and cleared at 0x28.
- R6: When an event for a bit arrives in the same cycle as a write that clears that bit, the bit ends up set.
- R7: `irq` is registered: one cycle after the pending and mask words hold a value it equals the OR of pending bits whose mask bit is zero, always excluding bits 5 and 21 (the excluded channel's full and half bits).
- R8: A read of 0xF0 returns `clrBusy[n]` in bit n and `auxStat[n]` in bit n+16; writes there have no effect.
- R9: A read of a set or clear alias returns the current value of its base word; a read of any address that holds no word returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWe | input | 1 | Write strobe, one cycle per write |
| busAddr | input | 8 | Byte address of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| fullEvt | input | NCH | Full-match event pulse per channel |
| halfEvt | input | NCH | Half-match event pulse per channel |
| clrBusy | input | NCH | Counter reset still running, per channel |
| auxStat | input | NCH | Second per-channel status indication |
| cntEnable | output | NCH | Counter enable per channel |
| chStop | output | NCH | Clock stop per channel |
| wdtStop | output | 1 | Clock stop for the watchdog |
| irq | output | 1 | Shared level interrupt, registered |

## Verification
On every cycle the assertions check that set and clear aliases leave the written bits of the enable, stop and mask words in the required state, that an event always leaves its pending bit set even against a clearing write, and that the interrupt follows the masked, exclusion-filtered pending word one cycle later. What the properties cannot show is the exact bit position of each channel's event in the pending word, the read-back of aliases and unmapped addresses, the status word layout and the reset values; the bench shows these by sweeping every channel, both event kinds and every stop bit through the bus.

// File: rtl/timer_ctrl_pkg.sv
package timer_ctrl_pkg;

  localparam int BUS_W = 32;
  localparam int HALF_OFS = 16;
  localparam int WDT_BIT = 16;

  localparam logic [7:0] ADR_EN_WR = 8'h10;
  localparam logic [7:0] ADR_EN_SET = 8'h14;
  localparam logic [7:0] ADR_EN_CLR = 8'h18;
  localparam logic [7:0] ADR_ST_WR = 8'h1C;
  localparam logic [7:0] ADR_ST_SET = 8'h2C;
  localparam logic [7:0] ADR_ST_CLR = 8'h3C;
  localparam logic [7:0] ADR_FL_WR = 8'h20;
  localparam logic [7:0] ADR_FL_SET = 8'h24;
  localparam logic [7:0] ADR_FL_CLR = 8'h28;
  localparam logic [7:0] ADR_MK_WR = 8'h30;
  localparam logic [7:0] ADR_MK_SET = 8'h34;
  localparam logic [7:0] ADR_MK_CLR = 8'h38;
  localparam logic [7:0] ADR_STATUS = 8'hF0;

  typedef enum logic [2:0] {
    RD_NONE, RD_EN, RD_ST, RD_FL, RD_MK, RD_STATUS
  } rdSel_e;

  // one write-kind triple per control word
  typedef struct packed {
    logic wr;
    logic set;
    logic clr;
  } wrKind_t;

  typedef struct packed {
    wrKind_t en;
    wrKind_t st;
    wrKind_t fl;
    wrKind_t mk;
    rdSel_e  rdSel;
  } ctrlStrobes_t;

  function automatic logic [BUS_W-1:0] applyWrite(
    input logic [BUS_W-1:0] cur,
    input wrKind_t          kind,
    input logic [BUS_W-1:0] data
  );
    logic [BUS_W-1:0] nxt;
    nxt = kind.wr ? data : cur;
    if (kind.set) nxt = nxt | data;
    if (kind.clr) nxt = nxt & ~data;
    return nxt;
  endfunction

endpackage

// File: rtl/timer_ctrl_decode.sv
module timer_ctrl_decode
  import timer_ctrl_pkg::*;
(
  input  logic         busWe,
  input  logic [7:0]   busAddr,
  output ctrlStrobes_t strobes
);

  always_comb begin
    strobes = '0;
    strobes.rdSel = RD_NONE;
    unique case (busAddr)
      ADR_EN_WR:  begin strobes.en.wr  = busWe; strobes.rdSel = RD_EN; end
      ADR_EN_SET: begin strobes.en.set = busWe; strobes.rdSel = RD_EN; end
      ADR_EN_CLR: begin strobes.en.clr = busWe; strobes.rdSel = RD_EN; end
      ADR_ST_WR:  begin strobes.st.wr  = busWe; strobes.rdSel = RD_ST; end
      ADR_ST_SET: begin strobes.st.set = busWe; strobes.rdSel = RD_ST; end
      ADR_ST_CLR: begin strobes.st.clr = busWe; strobes.rdSel = RD_ST; end
      ADR_FL_WR:  begin strobes.fl.wr  = busWe; strobes.rdSel = RD_FL; end
      ADR_FL_SET: begin strobes.fl.set = busWe; strobes.rdSel = RD_FL; end
      ADR_FL_CLR: begin strobes.fl.clr = busWe; strobes.rdSel = RD_FL; end
      ADR_MK_WR:  begin strobes.mk.wr  = busWe; strobes.rdSel = RD_MK; end
      ADR_MK_SET: begin strobes.mk.set = busWe; strobes.rdSel = RD_MK; end
      ADR_MK_CLR: begin strobes.mk.clr = busWe; strobes.rdSel = RD_MK; end
      ADR_STATUS: strobes.rdSel = RD_STATUS;
      default:    strobes.rdSel = RD_NONE;
    endcase
  end

endmodule

// File: rtl/timer_ctrl_regs.sv
module timer_ctrl_regs
  import timer_ctrl_pkg::*;
#(
  parameter int NCH = 16,
  parameter int EXCL_CH = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [BUS_W-1:0] busWdata,
  input  logic [NCH-1:0]   fullEvt,
  input  logic [NCH-1:0]   halfEvt,
  input  logic [NCH-1:0]   clrBusy,
  input  logic [NCH-1:0]   auxStat,
  output logic [BUS_W-1:0] rdData,
  output logic [BUS_W-1:0] enWord,
  output logic [BUS_W-1:0] stWord,
  output logic [BUS_W-1:0] flWord,
  output logic [BUS_W-1:0] mkWord,
  output logic             irqOut
);

  localparam logic [BUS_W-1:0] CH_BITS = (BUS_W'(1) << NCH) - BUS_W'(1);
  localparam logic [BUS_W-1:0] EVT_BITS = CH_BITS | (CH_BITS << HALF_OFS);
  localparam logic [BUS_W-1:0] STOP_BITS = CH_BITS | (BUS_W'(1) << WDT_BIT);
  localparam logic [BUS_W-1:0] EXCL_BITS =
    (BUS_W'(1) << EXCL_CH) | (BUS_W'(1) << (EXCL_CH + HALF_OFS));
  localparam logic [BUS_W-1:0] IRQ_BITS = EVT_BITS & ~EXCL_BITS;

  logic [BUS_W-1:0] evtVec;
  assign evtVec = (BUS_W'(halfEvt) << HALF_OFS) | BUS_W'(fullEvt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enWord <= '0;
      stWord <= '0;
      flWord <= '0;
      mkWord <= '0;
      irqOut <= 1'b0;
    end else begin
      enWord <= applyWrite(enWord, strobes.en, busWdata) & CH_BITS;
      stWord <= applyWrite(stWord, strobes.st, busWdata) & STOP_BITS;
      // events are ORed after the write so they win a same-cycle clear
      flWord <= (applyWrite(flWord, strobes.fl, busWdata) | evtVec) & EVT_BITS;
      mkWord <= applyWrite(mkWord, strobes.mk, busWdata) & EVT_BITS;
      irqOut <= |(flWord & ~mkWord & IRQ_BITS);
    end
  end

  always_comb begin
    unique case (strobes.rdSel)
      RD_EN:     rdData = enWord;
      RD_ST:     rdData = stWord;
      RD_FL:     rdData = flWord;
      RD_MK:     rdData = mkWord;
      RD_STATUS: rdData = (BUS_W'(auxStat) << HALF_OFS) | BUS_W'(clrBusy);
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/timer_ctrl_bank.sv
module timer_ctrl_bank
  import timer_ctrl_pkg::*;
#(
  parameter int NCH = 16,
  parameter int EXCL_CH = 5
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           busWe,
  input  logic [7:0]     busAddr,
  input  logic [31:0]    busWdata,
  output logic [31:0]    busRdata,
  input  logic [NCH-1:0] fullEvt,
  input  logic [NCH-1:0] halfEvt,
  input  logic [NCH-1:0] clrBusy,
  input  logic [NCH-1:0] auxStat,
  output logic [NCH-1:0] cntEnable,
  output logic [NCH-1:0] chStop,
  output logic           wdtStop,
  output logic           irq
);

  ctrlStrobes_t strobes;
  logic [BUS_W-1:0] enWord;
  logic [BUS_W-1:0] stWord;
  logic [BUS_W-1:0] flagQ;
  logic [BUS_W-1:0] maskQ;

  timer_ctrl_decode u_decode (
    .busWe   (busWe),
    .busAddr (busAddr),
    .strobes (strobes)
  );

  timer_ctrl_regs #(.NCH(NCH), .EXCL_CH(EXCL_CH)) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .busWdata (busWdata),
    .fullEvt  (fullEvt),
    .halfEvt  (halfEvt),
    .clrBusy  (clrBusy),
    .auxStat  (auxStat),
    .rdData   (busRdata),
    .enWord   (enWord),
    .stWord   (stWord),
    .flWord   (flagQ),
    .mkWord   (maskQ),
    .irqOut   (irq)
  );

  assign cntEnable = enWord[NCH-1:0];
  assign chStop    = stWord[NCH-1:0];
  assign wdtStop   = stWord[WDT_BIT];

endmodule

// File: rtl/timer_ctrl_bank_chk.sv
module timer_ctrl_bank_chk
  import timer_ctrl_pkg::*;
#(
  parameter int NCH = 16,
  parameter int EXCL_CH = 5
) (
  input logic           clk,
  input logic           rstN,
  input logic           busWe,
  input logic [7:0]     busAddr,
  input logic [31:0]    busWdata,
  input logic [NCH-1:0] fullEvt,
  input logic [NCH-1:0] halfEvt,
  input logic [NCH-1:0] cntEnable,
  input logic [NCH-1:0] chStop,
  input logic           irq,
  input logic [31:0]    flagQ,
  input logic [31:0]    maskQ
);

  localparam logic [31:0] EXCL_BITS =
    (32'h1 << EXCL_CH) | (32'h1 << (EXCL_CH + HALF_OFS));

  logic [31:0] evtVec;
  assign evtVec = (32'(halfEvt) << HALF_OFS) | 32'(fullEvt);

  p_en_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADR_EN_SET) |=>
      ((cntEnable & $past(busWdata[NCH-1:0])) == $past(busWdata[NCH-1:0])));

  p_en_clr_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADR_EN_CLR) |=>
      ((cntEnable & $past(busWdata[NCH-1:0])) == '0));

  p_stop_clr_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADR_ST_CLR) |=>
      ((chStop & $past(busWdata[NCH-1:0])) == '0));

  p_mask_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADR_MK_SET) |=>
      ((maskQ & $past(busWdata) & 32'h00FF_00FF) == ($past(busWdata) & 32'h00FF_00FF)));

  p_evt_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    (|evtVec) |=> ((flagQ & $past(evtVec)) == $past(evtVec)));

  p_irq_follow_r7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irq == $past(|(flagQ & ~maskQ & ~EXCL_BITS))));

endmodule

bind timer_ctrl_bank timer_ctrl_bank_chk #(.NCH(NCH), .EXCL_CH(EXCL_CH)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busWe     (busWe),
  .busAddr   (busAddr),
  .busWdata  (busWdata),
  .fullEvt   (fullEvt),
  .halfEvt   (halfEvt),
  .cntEnable (cntEnable),
  .chStop    (chStop),
  .irq       (irq),
  .flagQ     (flagQ),
  .maskQ     (maskQ)
);

// File: tb/timer_ctrl_bank_tb.sv
module timer_ctrl_bank_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 16;
  localparam int WATCHDOG_CYCLES = 50000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWe = 1'b0;
  logic [7:0] busAddr = 8'h00;
  logic [31:0] busWdata = 32'h0;
  logic [31:0] busRdata;
  logic [NCH-1:0] fullEvt = '0;
  logic [NCH-1:0] halfEvt = '0;
  logic [NCH-1:0] clrBusy = '0;
  logic [NCH-1:0] auxStat = '0;
  logic [NCH-1:0] cntEnable;
  logic [NCH-1:0] chStop;
  logic wdtStop;
  logic irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  timer_ctrl_bank #(.NCH(NCH), .EXCL_CH(5)) u_dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .fullEvt(fullEvt),
    .halfEvt(halfEvt), .clrBusy(clrBusy), .auxStat(auxStat),
    .cntEnable(cntEnable), .chStop(chStop), .wdtStop(wdtStop), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic checkRead(input logic [7:0] a, input logic [31:0] exp, input string req);
    logic [31:0] v;
    busRead(a, v);
    check(v === exp, req, v, exp);
  endtask

  function automatic bit allowed(input int bitIdx);
    return !(bitIdx == 5 || bitIdx == 21);
  endfunction

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    checkRead(8'h10, 32'h0, "R1 enable");
    checkRead(8'h1C, 32'h0, "R1 stop");
    checkRead(8'h20, 32'h0, "R1 pending");
    checkRead(8'h30, 32'h0, "R1 mask");
    check({cntEnable, chStop, wdtStop, irq} === '0, "R1 outputs",
          32'({cntEnable, chStop, wdtStop, irq}), 32'h0);

    // R2: enable word, aliases, unused bits
    busWrite(8'h10, 32'h0000_A5A5);
    check(cntEnable === 16'hA5A5, "R2 base write", 32'(cntEnable), 32'hA5A5);
    busWrite(8'h14, 32'h0000_0F00);
    check(cntEnable === 16'hAFA5, "R2 set alias", 32'(cntEnable), 32'hAFA5);
    busWrite(8'h18, 32'h0000_00A0);
    check(cntEnable === 16'hAF05, "R2 clear alias", 32'(cntEnable), 32'hAF05);
    checkRead(8'h14, 32'h0000_AF05, "R9 set alias read");
    checkRead(8'h18, 32'h0000_AF05, "R9 clear alias read");
    busWrite(8'h10, 32'hFFFF_0001);
    checkRead(8'h10, 32'h0000_0001, "R2 unused bits");

    // R3: sweep every stop bit including watchdog bit 16
    for (int n = 0; n <= 16; n++) begin
      logic [31:0] exp;
      busWrite(8'h2C, 32'h1 << n);
      exp = (32'h1 << (n + 1)) - 1;
      checkRead(8'h1C, exp, "R3 stop set sweep");
      check({wdtStop, chStop} === exp[16:0], "R3 stop outputs",
            32'({wdtStop, chStop}), exp);
    end
    for (int n = 0; n <= 16; n++) busWrite(8'h3C, 32'h1 << n);
    checkRead(8'h1C, 32'h0, "R3 stop clear sweep");
    busWrite(8'h1C, 32'hFFFF_FFFF);
    checkRead(8'h1C, 32'h0001_FFFF, "R3 stop base write");
    check(wdtStop === 1'b1, "R3 watchdog stop", 32'(wdtStop), 32'h1);
    busWrite(8'h1C, 32'h0);

    // R4: mask word
    busWrite(8'h30, 32'hFFFF_FFFF);
    checkRead(8'h30, 32'hFFFF_FFFF, "R4 mask base");
    busWrite(8'h38, 32'h00F0_000F);
    checkRead(8'h34, 32'hFF0F_FFF0, "R4 mask clear / R9");
    busWrite(8'h30, 32'h0);

    // R5 / R7: every channel, both event kinds, unmasked then masked
    for (int n = 0; n < NCH; n++) begin
      for (int h = 0; h < 2; h++) begin
        int b;
        b = n + 16 * h;
        for (int m = 0; m < 2; m++) begin
          if (m == 1) busWrite(8'h34, 32'h1 << b);
          @(negedge clk);
          if (h == 0) fullEvt[n] = 1'b1; else halfEvt[n] = 1'b1;
          @(negedge clk);
          fullEvt = '0; halfEvt = '0;
          checkRead(8'h20, 32'h1 << b, "R5 event bit position");
          check(irq === 1'b0, "R7 irq registered delay", 32'(irq), 32'h0);
          @(negedge clk);
          check(irq === (allowed(b) && m == 0), "R7 irq level",
                32'(irq), 32'(allowed(b) && m == 0));
          busWrite(8'h28, 32'h1 << b);
          checkRead(8'h20, 32'h0, "R5 pending clear");
          @(negedge clk);
          check(irq === 1'b0, "R7 irq drops", 32'(irq), 32'h0);
          if (m == 1) busWrite(8'h38, 32'h1 << b);
        end
      end
    end

    // R5: software set of pending bits, excluded channel stays silent
    busWrite(8'h24, 32'h0020_0020);
    @(negedge clk);
    check(irq === 1'b0, "R7 excluded channel", 32'(irq), 32'h0);
    busWrite(8'h24, 32'h0000_0010);
    @(negedge clk);
    check(irq === 1'b1, "R7 set alias raises irq", 32'(irq), 32'h1);
    checkRead(8'h20, 32'h0020_0030, "R5 set alias");
    busWrite(8'h20, 32'h0);
    checkRead(8'h20, 32'h0, "R5 base write");

    // R6: event against same-cycle clear
    busWrite(8'h24, 32'h0008_0008);
    @(negedge clk);
    busAddr = 8'h28; busWdata = 32'h0008_0008; busWe = 1'b1;
    fullEvt[3] = 1'b1;
    @(negedge clk);
    busWe = 1'b0; fullEvt = '0;
    checkRead(8'h20, 32'h0000_0008, "R6 event beats clear");
    busWrite(8'h28, 32'hFFFF_FFFF);

    // R8: status word, writes ignored
    clrBusy = 16'h1234; auxStat = 16'hBEEF;
    busWrite(8'hF0, 32'h0);
    checkRead(8'hF0, 32'hBEEF_1234, "R8 status word");
    checkRead(8'h10, 32'h0000_0001, "R8 status write no effect");

    // R9: unmapped address
    checkRead(8'h40, 32'h0, "R9 unmapped read");

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG_CYCLES) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG_CYCLES);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule